// File: doc/BRIEF.md
# I2C Word-Register Target with Broadcast Write

This block is the serial target side of a register-access port. It watches a two-wire I2C bus through its system clock, which runs much faster than the bus clock. It recognises bus start, repeated start and stop conditions. It answers its own 7-bit address, which is made of the fixed prefix `100` followed by four strap bits. For writes only, it also answers a shared broadcast address, so that a host can configure many devices with a single transaction.

A write sets an 8-bit register pointer and then stores one 16-bit word. The word arrives low byte first. A read returns 16-bit words high byte first. The pointer steps forward after each word, and words keep flowing for as long as the host acknowledges. Registers `00h` to `09h` are backed by an external register bank through a simple strobe port. Addresses above that read as zero and ignore writes. The block also spots the high-speed master code and keeps a mode flag until the next stop.

The data line is driven only as an open-drain low, through an output enable. Both bus lines pass through two-flop synchronisers.

Top module: `i2cw_target`

## Requirements
- R1: The address byte `{3'b100, strap_i, rw}` is acknowledged, which means the data line is held low during the ninth clock. An address byte with any other strap value gets no acknowledge, and the data line is never driven for the rest of that transaction.
- R2: The broadcast address `7'b0111111` with rw=0 (byte 7Eh) is acknowledged and performs a normal write. With rw=1 (byte 7Fh) it is not acknowledged.
- R3: A write transaction sends the address byte, then a pointer byte, then a low data byte, then a high data byte, and each of these is acknowledged. After the high byte, `wr_en_o` pulses for exactly one clock with `wr_addr_o` equal to the pointer and `wr_data_o` equal to {high, low}. The pointer is not changed by the data bytes.
- R4: After both data bytes of a write, every further data byte gets no acknowledge, and no further write strobe occurs before a new start.
- R5: A random read is a write of the address and the pointer byte, then a repeated start, then the address byte with rw=1. It returns the register at that pointer, bits 15..8 first and then bits 7..0.
- R6: While the host acknowledges, reading continues. The pointer advances by one after each 16-bit word, and the next word comes from the new pointer.
- R7: After reset the pointer is 00h, so a read with no pointer byte starts at register 00h.
- R8: Registers above 09h read as 0000h, whatever `rd_data_i` carries. Writes to those addresses are acknowledged but give no `wr_en_o` pulse.
- R9: A byte of the form `00001xxx` received after a start is not acknowledged, and it sets `hs_mode_o`. The flag stays set across repeated starts and is cleared only by a stop.
- R10: The block only pulls the data line low, through `sda_oe_o`. `sda_oe_o` changes only while SCL is low, and it is released after a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| strap_i | input | 4 | Low four bits of the device address |
| sda_oe_o | output | 1 | When 1, pull the data line low |
| hs_mode_o | output | 1 | High-speed mode flag |
| wr_en_o | output | 1 | One-clock register write strobe |
| wr_addr_o | output | 8 | Register index for the write |
| wr_data_o | output | 16 | Word to write |
| rd_addr_o | output | 8 | Register index being read |
| rd_data_i | input | 16 | Word at `rd_addr_o`, valid in the same clock |

## Verification
The assertions assume a well-behaved bus. The host changes SDA only while SCL is low, except when it makes a start or a stop. It never makes a start or a stop while the block holds the line low. Each SCL phase also lasts several system clocks longer than the synchroniser delay.

The bench master drives SCL in quarter-periods of ten system clocks. It changes its data bit only in the low phase. It makes start and stop conditions only after the target has released the line. It models the wire as the AND of both drivers, and it counts any change of the enable that happens while SCL is high.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
    parameter int DATA_W = 16;
    parameter int PTR_W  = 8;
    parameter int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_SKIP
    } tstate_t;

    typedef struct packed {
        tstate_t             st;
        logic [3:0]          bitcnt;
        logic [BYTE_W-1:0]   shreg;
        logic [PTR_W-1:0]    ptr;
        logic [BYTE_W-1:0]   lo;
        logic [1:0]          idx;
        logic                rw;
        logic [DATA_W-1:0]   txw;
        logic                bsel;
        logic                oe;
        logic                hs;
        logic                mack;
        logic                wr_en;
        logic [DATA_W-1:0]   wr_data;
    } tgt_regs_t;
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q, chain_d;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2cw_cond.sv
module i2cw_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic scl_prev_q, sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_s;
            sda_prev_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_prev_q;
    assign scl_fall  = ~scl_s & scl_prev_q;
    assign bus_start = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign bus_stop  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/i2cw_target.sv
module i2cw_target
    import i2cw_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [PTR_W-1:0]  LAST_REG    = 8'h09,
    parameter logic [2:0]        ADDR_PREFIX = 3'b100,
    parameter logic [6:0]        BCAST_ADDR  = 7'b0111111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [3:0]        strap_i,
    output logic              sda_oe_o,
    output logic              hs_mode_o,
    output logic              wr_en_o,
    output logic [PTR_W-1:0]  wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [PTR_W-1:0]  rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i
);
    localparam logic [3:0] BIT_LAST = 4'(BYTE_W);
    localparam int         HALF_W   = DATA_W / 2;

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, bus_start, bus_stop;

    i2cw_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
        .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));
    i2cw_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
        .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

    i2cw_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop));

    tgt_regs_t q, d;
    logic [DATA_W-1:0] word_rd;
    logic [BYTE_W-1:0] tx_byte;
    logic              tx_bit;

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        word_rd = (q.ptr <= LAST_REG) ? rd_data_i : '0;
        tx_byte = q.bsel ? q.txw[HALF_W-1:0] : q.txw[DATA_W-1:HALF_W];
        tx_bit  = tx_byte[3'd7 - q.bitcnt[2:0]];

        if (bus_stop) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
            d.hs = 1'b0;
        end else if (bus_start) begin
            d.st     = ST_ADDR;
            d.bitcnt = '0;
            d.oe     = 1'b0;
            d.idx    = '0;
        end else begin
            unique case (q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        d.shreg  = {q.shreg[BYTE_W-2:0], sda_s};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall && q.bitcnt == BIT_LAST) begin
                        if (q.shreg[7:3] == 5'b00001) begin
                            d.hs = 1'b1;
                            d.st = ST_SKIP;
                        end else if (q.shreg[7:1] == {ADDR_PREFIX, strap_i}) begin
                            d.rw = q.shreg[0];
                            d.oe = 1'b1;
                            d.st = ST_ACK;
                        end else if (q.shreg[7:1] == BCAST_ADDR && !q.shreg[0]) begin
                            d.rw = 1'b0;
                            d.oe = 1'b1;
                            d.st = ST_ACK;
                        end else begin
                            d.st = ST_SKIP;
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise) begin
                        d.shreg  = {q.shreg[BYTE_W-2:0], sda_s};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall && q.bitcnt == BIT_LAST) begin
                        d.oe  = 1'b1;
                        d.st  = ST_ACK;
                        d.idx = q.idx + 2'd1;
                        unique case (q.idx)
                            2'd0: d.ptr = q.shreg;
                            2'd1: d.lo  = q.shreg;
                            2'd2: begin
                                d.wr_en   = (q.ptr <= LAST_REG);
                                d.wr_data = {q.shreg, q.lo};
                            end
                            default: begin
                                d.oe  = 1'b0;
                                d.st  = ST_SKIP;
                                d.idx = q.idx;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.bitcnt = '0;
                        if (q.rw) begin
                            d.txw  = word_rd;
                            d.bsel = 1'b0;
                            d.oe   = ~word_rd[DATA_W-1];
                            d.st   = ST_TX;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.bitcnt == BIT_LAST) begin
                            d.oe = 1'b0;
                            d.st = ST_MACK;
                            if (q.bsel) d.ptr = q.ptr + 1'b1;
                        end else begin
                            d.oe = ~tx_bit;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        d.bitcnt = '0;
                        if (!q.mack) begin
                            d.st = ST_SKIP;
                        end else if (!q.bsel) begin
                            d.bsel = 1'b1;
                            d.oe   = ~q.txw[HALF_W-1];
                            d.st   = ST_TX;
                        end else begin
                            d.txw  = word_rd;
                            d.bsel = 1'b0;
                            d.oe   = ~word_rd[DATA_W-1];
                            d.st   = ST_TX;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o  = q.oe;
    assign hs_mode_o = q.hs;
    assign wr_en_o   = q.wr_en;
    assign wr_addr_o = q.ptr;
    assign wr_data_o = q.wr_data;
    assign rd_addr_o = q.ptr;

    // R10: enable moves only while the synchronised clock is low
    a_r10_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (q.oe != $past(q.oe)) |-> !scl_s);

    // R10: a stop always leaves the line released
    a_r10_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !q.oe);

    // R3: the write strobe is a single-cycle pulse
    a_r3_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_en |=> !q.wr_en);

    // R8: no strobe beyond the last backed register
    a_r8_strobe_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_en |-> (q.ptr <= LAST_REG));

    // R9: high-speed flag drops only after a stop
    a_r9_hs_clear_by_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.hs) |-> $past(bus_stop));
endmodule

// File: tb/i2cw_target_tb.sv
module i2cw_target_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam logic [3:0] STRAP = 4'b0110;
    localparam logic [7:0] A_WR  = {3'b100, STRAP, 1'b0};
    localparam logic [7:0] A_RD  = {3'b100, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe, hs_mode, wr_en;
    logic [7:0]  wr_addr, rd_addr;
    logic [15:0] wr_data, rd_data;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int r10_viol = 0;
    bit done = 1'b0;

    logic [15:0] regs [0:9];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = ~(m_low | sda_oe);
    assign rd_data  = (rd_addr < 8'd10) ? regs[rd_addr] : 16'hDEAD;

    function automatic logic [15:0] init_val(input int i);
        return 16'hA5C3 ^ (16'(i) * 16'h1111);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 10; i++) regs[i] <= init_val(i);
        end else if (wr_en) begin
            wr_cnt <= wr_cnt + 1;
            if (wr_addr < 8'd10) regs[wr_addr] <= wr_data;
        end
    end

    logic oe_prev = 1'b0;
    always @(posedge clk) begin
        if (rst_n && sda_oe != oe_prev && scl) r10_viol <= r10_viol + 1;
        oe_prev <= sda_oe;
    end

    i2cw_target u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .strap_i(STRAP), .sda_oe_o(sda_oe), .hs_mode_o(hs_mode),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .rd_addr_o(rd_addr), .rd_data_i(rd_data));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; qwait(); scl = 1'b1; qwait();
        m_low = 1'b1; qwait(); scl = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; qwait(); scl = 1'b1; qwait();
        m_low = 1'b0; qwait();
    endtask

    task automatic clk_bit(input logic drive_low, output logic seen);
        m_low = drive_low; qwait(); scl = 1'b1; qwait();
        seen = sda_line; qwait(); scl = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(!b[i], s);
        clk_bit(1'b0, s);
        ack = !s;
        m_low = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b0, s);
            b[i] = s;
        end
        clk_bit(give_ack, s);
        m_low = 1'b0;
    endtask

    task automatic recv_word(input logic ack_last, output logic [15:0] w);
        logic [7:0] hi, lo;
        recv_byte(1'b1, hi);
        recv_byte(ack_last, lo);
        w = {hi, lo};
    endtask

    task automatic t_reset();
        chk(sda_oe == 1'b0, "R10 reset enable", sda_oe, 0);
        chk(hs_mode == 1'b0, "R9 reset flag", hs_mode, 0);
        chk(wr_en == 1'b0, "R3 reset strobe", wr_en, 0);
    endtask

    task automatic t_current_read();
        logic a; logic [15:0] w;
        bus_start();
        send_byte(A_RD, a);
        chk(a, "R1 own address read ack", a, 1);
        recv_word(1'b1, w);
        chk(w == init_val(0), "R7 current read from 00h", w, init_val(0));
        recv_word(1'b0, w);
        chk(w == init_val(1), "R6 next word after ack", w, init_val(1));
        bus_stop();
    endtask

    task automatic t_write();
        logic a0, a1, a2, a3, a4; int c0; logic [15:0] w;
        c0 = wr_cnt;
        bus_start();
        send_byte(A_WR, a0); send_byte(8'h03, a1);
        send_byte(8'h78, a2); send_byte(8'h56, a3);
        chk(a0 && a1 && a2 && a3, "R3 four bytes acked", {a0, a1, a2, a3}, 4'hF);
        chk(wr_cnt == c0 + 1, "R3 one strobe", wr_cnt - c0, 1);
        chk(regs[3] == 16'h5678, "R3 word low byte first", regs[3], 16'h5678);
        send_byte(8'hAA, a4);
        chk(!a4, "R4 extra byte nacked", a4, 0);
        bus_stop();
        chk(wr_cnt == c0 + 1, "R4 no second strobe", wr_cnt - c0, 1);
        chk(regs[3] == 16'h5678, "R4 register unchanged", regs[3], 16'h5678);
        bus_start(); send_byte(A_RD, a0); recv_word(1'b0, w); bus_stop();
        chk(w == 16'h5678, "R3 pointer kept by data bytes", w, 16'h5678);
    endtask

    task automatic t_random_read();
        logic a0, a1, a2; logic [15:0] w;
        bus_start(); send_byte(A_WR, a0); send_byte(8'h07, a1);
        bus_start(); send_byte(A_RD, a2);
        chk(a0 && a1 && a2, "R5 three bytes acked", {a0, a1, a2}, 3'h7);
        recv_word(1'b1, w);
        chk(w == init_val(7), "R5 random read MSB first", w, init_val(7));
        recv_word(1'b1, w);
        chk(w == init_val(8), "R6 increment to 08h", w, init_val(8));
        recv_word(1'b0, w);
        chk(w == init_val(9), "R6 increment to 09h", w, init_val(9));
        bus_stop();
    endtask

    task automatic t_wrong_addr();
        logic a; int c0;
        c0 = wr_cnt;
        bus_start(); send_byte({3'b100, 4'b0111, 1'b0}, a);
        chk(!a, "R1 other strap nacked", a, 0);
        send_byte(8'h02, a);
        chk(!a && !sda_oe, "R1 idle after mismatch", {a, sda_oe}, 0);
        bus_stop();
        chk(wr_cnt == c0, "R1 no strobe", wr_cnt - c0, 0);
    endtask

    task automatic t_broadcast();
        logic a0, a1, a2, a3;
        bus_start(); send_byte(8'h7E, a0); send_byte(8'h05, a1);
        send_byte(8'hCD, a2); send_byte(8'hAB, a3); bus_stop();
        chk(a0 && a1 && a2 && a3, "R2 broadcast write acked", {a0, a1, a2, a3}, 4'hF);
        chk(regs[5] == 16'hABCD, "R2 broadcast write stored", regs[5], 16'hABCD);
        bus_start(); send_byte(8'h7F, a0);
        chk(!a0, "R2 broadcast read nacked", a0, 0);
        bus_stop();
    endtask

    task automatic t_ceiling();
        logic a0, a1, a2, a3; int c0; logic [15:0] w;
        c0 = wr_cnt;
        bus_start(); send_byte(A_WR, a0); send_byte(8'h0A, a1);
        send_byte(8'h11, a2); send_byte(8'h22, a3); bus_stop();
        chk(a0 && a1 && a2 && a3, "R8 high write acked", {a0, a1, a2, a3}, 4'hF);
        chk(wr_cnt == c0, "R8 high write no strobe", wr_cnt - c0, 0);
        bus_start(); send_byte(A_WR, a0); send_byte(8'h09, a1);
        bus_start(); send_byte(A_RD, a2);
        recv_word(1'b1, w);
        chk(w == init_val(9), "R8 last valid register", w, init_val(9));
        recv_word(1'b0, w);
        chk(w == 16'h0000, "R8 above 09h reads zero", w, 16'h0000);
        bus_stop();
    endtask

    task automatic t_hs();
        logic a; logic [15:0] w;
        bus_start(); send_byte(8'h0D, a);
        chk(!a, "R9 master code nacked", a, 0);
        chk(hs_mode, "R9 flag set", hs_mode, 1);
        bus_start(); send_byte(A_WR, a); send_byte(8'h00, a);
        bus_start();
        chk(hs_mode, "R9 flag kept over restart", hs_mode, 1);
        send_byte(A_RD, a);
        recv_word(1'b0, w);
        chk(a && w == init_val(0), "R9 transfer in high-speed", w, init_val(0));
        bus_stop();
        chk(!hs_mode, "R9 cleared by stop", hs_mode, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_current_read();
        t_write();
        t_random_read();
        t_wrong_addr();
        t_broadcast();
        t_ceiling();
        t_hs();
        qwait();
        chk(r10_viol == 0, "R10 enable changed with SCL high", r10_viol, 0);
        chk(!sda_oe, "R10 released at end", sda_oe, 0);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule